// File: doc/BRIEF.md
# Table-Coded Clock Divider with Output Gate

This block derives a slower clock from a parent clock. Software writes a single control word: a 4-bit code in its low bits picks the division ratio from a fixed table, and one further bit turns the divided output off. The table is sparse and is not limited to powers of two. It holds ratios between 3 and 48, and the only odd one is 3. A parameter selects a second variant of the table. That variant adds divide-by-2 on code 0 and divide-by-10 on code 12.

The output keeps a 50 percent duty cycle for every ratio. For an even ratio a counter on the rising parent edge is enough. For an odd ratio, a copy of the counter phase is retimed on the falling edge, and the two are ANDed so that the high time is exactly half the period. New ratios and changes to the gate take effect only when the current output period ends. The output therefore never shows a shortened high or low phase. If the code written is not in the table, the ratio already requested stays in place and a sticky error output is raised.

Top module: `tbl_clk_div`

## Requirements
- R1: While reset is asserted and after its release, the ratio is 3 (the ratio of code 1) with the output enabled, `cfg_err` is 0 and `clk_out` is 0 until the first period starts.
- R2: With the primary table (`TABLE_VARIANT`=0), `wr_data[3:0]` selects the ratio as follows: 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48.
- R3: For an even ratio N, `clk_out` is high for N/2 parent cycles starting at a rising parent edge and then low for N/2 cycles.
- R4: For an odd ratio N, `clk_out` rises on the falling parent edge in the first cycle of a period and stays high for exactly N half-cycles of the parent clock, which is a 50 percent duty cycle.
- R5: Writing a code with no table entry (codes 0, 9 and 12 to 15 in the primary table) leaves the requested ratio unchanged.
- R6: Any write with a code that has no table entry sets `cfg_err`. It stays at 1 until reset, including across later valid writes.
- R7: A written ratio takes effect at the first output period that starts after the write. The period in progress completes at its old length. If several writes land in one period, the last one wins.
- R8: `wr_data[8]`=1 disables the output and 0 enables it. The bit is taken on every write, even one with an invalid code. The change applies at the next period boundary: a disabled output stays at 0, and an enabled output restarts with a full high phase.
- R9: With `TABLE_VARIANT`=1, code 0 selects ratio 2 and code 12 selects ratio 10, and all other codes behave as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe, sampled on the rising edge |
| wr_data | input | REG_W | Control word: ratio code in bits 3:0, disable bit at bit 8 |
| clk_out | output | 1 | Divided and gated clock |
| cfg_err | output | 1 | Sticky flag for a write with an unlisted code |

## Verification
The bench aims at the ratio-3 case, because it depends on the falling-edge path. A design that used a plain counter there would give a high phase of 2 cycles and a low phase of 1 instead of 1.5 cycles each. Writes land in the middle of a period, including two writes within one period. These catch a design that switches ratio at once, which would produce a runt pulse or a stretched phase, and one that keeps the first write instead of the last. Unlisted codes are written, including one combined with the disable bit. This exposes a design that loads a zero or garbage ratio, drops the gate update, or clears the error flag too early. A second instance with the alternate table checks that codes 0 and 12 decode only in that variant.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

   localparam int CODE_W   = 4;
   localparam int RATIO_W  = 8;
   localparam int GATE_BIT = 8;
   localparam logic [CODE_W-1:0] RST_CODE = 4'd1;

   typedef struct packed {
      logic               ok;
      logic [RATIO_W-1:0] ratio;
   } ratio_t;

   // Code-to-ratio decode; variant 1 fills codes 0 and 12.
   function automatic ratio_t code_to_ratio(input logic [CODE_W-1:0] code,
                                            input int variant);
      ratio_t r;
      r.ok    = 1'b1;
      r.ratio = '0;
      case (code)
         4'd1:    r.ratio = 8'd3;
         4'd2:    r.ratio = 8'd4;
         4'd3:    r.ratio = 8'd6;
         4'd4:    r.ratio = 8'd8;
         4'd5:    r.ratio = 8'd12;
         4'd6:    r.ratio = 8'd16;
         4'd7:    r.ratio = 8'd18;
         4'd8:    r.ratio = 8'd24;
         4'd10:   r.ratio = 8'd36;
         4'd11:   r.ratio = 8'd48;
         4'd0: begin
            if (variant == 1) r.ratio = 8'd2;
            else              r.ok    = 1'b0;
         end
         4'd12: begin
            if (variant == 1) r.ratio = 8'd10;
            else              r.ok    = 1'b0;
         end
         default: r.ok = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tcd_ctrl.sv
module tcd_ctrl #(
   parameter int REG_W         = 16,
   parameter int CNT_W         = 6,
   parameter int TABLE_VARIANT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [CNT_W-1:0] ratio_req,
   output logic             gate_req,
   output logic             cfg_err
);
   import tcd_pkg::*;

   localparam ratio_t RST_DEC = code_to_ratio(RST_CODE, TABLE_VARIANT);
   localparam logic [CNT_W-1:0] RST_RATIO = RST_DEC.ratio[CNT_W-1:0];

   ratio_t dec;
   assign dec = code_to_ratio(wr_data[CODE_W-1:0], TABLE_VARIANT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_req <= RST_RATIO;
         gate_req  <= 1'b0;
         cfg_err   <= 1'b0;
      end else if (wr_en) begin
         gate_req <= wr_data[GATE_BIT];
         if (dec.ok) ratio_req <= dec.ratio[CNT_W-1:0];
         else        cfg_err   <= 1'b1;
      end
   end

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

   // R5
   bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !dec.ok) |=> $stable(ratio_req));

endmodule

// File: rtl/tcd_period.sv
module tcd_period #(
   parameter int               CNT_W     = 6,
   parameter logic [CNT_W-1:0] RST_RATIO = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] ratio_req,
   input  logic             gate_req,
   output logic             lead_q,
   output logic             ratio_odd
);
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [CNT_W-1:0] ratio_q, ratio_n;
   logic             en_q, en_n;
   logic [CNT_W:0]   high_len;
   logic             wrap;

   assign wrap     = (cnt_q == ratio_q - 1'b1);
   assign cnt_n    = wrap ? '0 : cnt_q + 1'b1;
   assign ratio_n  = wrap ? ratio_req : ratio_q;
   assign en_n     = wrap ? ~gate_req : en_q;
   assign high_len = ({1'b0, ratio_n} + 1'b1) >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= RST_RATIO - 1'b1;
         ratio_q <= RST_RATIO;
         en_q    <= 1'b1;
         lead_q  <= 1'b0;
      end else begin
         cnt_q   <= cnt_n;
         ratio_q <= ratio_n;
         en_q    <= en_n;
         lead_q  <= en_n && ({1'b0, cnt_n} < high_len);
      end
   end

   assign ratio_odd = ratio_q[0];

   // R7
   ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> $stable(ratio_q));

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < ratio_q);

   // R8
   gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !lead_q);

   // R8
   gate_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> $stable(en_q));

endmodule

// File: rtl/tcd_merge.sv
module tcd_merge (
   input  logic clk,
   input  logic rst_n,
   input  logic lead_q,
   input  logic ratio_odd,
   output logic clk_out
);
   logic lag_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) lag_q <= 1'b0;
      else        lag_q <= lead_q;
   end

   assign clk_out = ratio_odd ? (lead_q & lag_q) : lead_q;

   // R4
   lag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_odd && !lead_q) |-> !clk_out);

endmodule

// File: rtl/tbl_clk_div.sv
module tbl_clk_div #(
   parameter int REG_W         = 16,
   parameter int CNT_W         = 6,
   parameter int TABLE_VARIANT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic             clk_out,
   output logic             cfg_err
);
   import tcd_pkg::*;

   localparam ratio_t RST_DEC = code_to_ratio(RST_CODE, TABLE_VARIANT);
   localparam logic [CNT_W-1:0] RST_RATIO = RST_DEC.ratio[CNT_W-1:0];
   localparam int MAX_RATIO = 48;

   if (REG_W < GATE_BIT + 1) begin : g_bad_reg_w
      $error("REG_W too narrow for the gate bit");
   end
   if ((2 ** CNT_W) <= MAX_RATIO || CNT_W > RATIO_W) begin : g_bad_cnt_w
      $error("CNT_W cannot hold the largest ratio");
   end
   if (TABLE_VARIANT != 0 && TABLE_VARIANT != 1) begin : g_bad_variant
      $error("TABLE_VARIANT must be 0 or 1");
   end

   logic [CNT_W-1:0] ratio_req;
   logic             gate_req;
   logic             lead_q;
   logic             ratio_odd;

   tcd_ctrl #(
      .REG_W        (REG_W),
      .CNT_W        (CNT_W),
      .TABLE_VARIANT(TABLE_VARIANT)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .ratio_req(ratio_req),
      .gate_req (gate_req),
      .cfg_err  (cfg_err)
   );

   tcd_period #(
      .CNT_W    (CNT_W),
      .RST_RATIO(RST_RATIO)
   ) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .ratio_req(ratio_req),
      .gate_req (gate_req),
      .lead_q   (lead_q),
      .ratio_odd(ratio_odd)
   );

   tcd_merge u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lead_q   (lead_q),
      .ratio_odd(ratio_odd),
      .clk_out  (clk_out)
   );

endmodule

// File: tb/sim_tbl_clk_div.sv
module sim_tbl_clk_div;
   localparam int CLK_P = 10;
   localparam int REG_W = 16;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             wr_en;
   logic [REG_W-1:0] wr_data;
   logic [1:0]       co;
   logic [1:0]       ce;

   int    n_chk = 0;
   int    n_err = 0;
   string tag   = "R1";

   int mk[2], mn[2], men[2], pn[2], pg[2], merr[2];

   always #(CLK_P/2) clk = ~clk;

   tbl_clk_div #(.REG_W(REG_W), .CNT_W(6), .TABLE_VARIANT(0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .clk_out(co[0]), .cfg_err(ce[0]));

   tbl_clk_div #(.REG_W(REG_W), .CNT_W(6), .TABLE_VARIANT(1)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .clk_out(co[1]), .cfg_err(ce[1]));

   // Ratio per code from the requirements; 0 means no entry.
   function automatic int spec_ratio(input int code, input int variant);
      case (code)
         1: return 3;   2: return 4;   3: return 6;   4: return 8;
         5: return 12;  6: return 16;  7: return 18;  8: return 24;
         10: return 36; 11: return 48;
         0: return (variant == 1) ? 2 : 0;
         12: return (variant == 1) ? 10 : 0;
         default: return 0;
      endcase
   endfunction

   // Expected output level in half-slot h of a period of n cycles.
   function automatic logic spec_level(input int n, input int en, input int h);
      if (en == 0)         return 1'b0;
      else if (n % 2 == 0) return (h < n);
      else                 return (h >= 1 && h <= n);
   endfunction

   task automatic chk(input logic act, input logic exp,
                      input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t",
                  req, what, act, exp, $time);
      end
   endtask

   task automatic wr(input int code, input int gate);
      @(negedge clk);
      #1;
      wr_en   = 1'b1;
      wr_data = REG_W'(code) | (gate != 0 ? REG_W'(16'h0100) : '0);
      @(negedge clk);
      #1;
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   // Reference model and per-half-cycle comparison.
   initial begin
      for (int i = 0; i < 2; i++) begin
         mk[i] = 2; mn[i] = 3; men[i] = 1; pn[i] = 3; pg[i] = 0; merr[i] = 0;
      end
      @(posedge rst_n);
      forever begin
         @(posedge clk);
         for (int i = 0; i < 2; i++) begin
            int r;
            if (mk[i] == mn[i] - 1) begin
               mk[i] = 0; mn[i] = pn[i]; men[i] = (pg[i] == 0);
            end else begin
               mk[i]++;
            end
            r = spec_ratio(int'(wr_data[3:0]), i);
            if (wr_en) begin
               if (r != 0) pn[i] = r;
               else        merr[i] = 1;
               pg[i] = int'(wr_data[8]);
            end
         end
         #3;
         for (int i = 0; i < 2; i++) begin
            chk(co[i], spec_level(mn[i], men[i], 2*mk[i]), tag, "clk_out high half");
            chk(ce[i], logic'(merr[i]), "R6", "cfg_err");
         end
         @(negedge clk);
         #3;
         for (int i = 0; i < 2; i++)
            chk(co[i], spec_level(mn[i], men[i], 2*mk[i]+1), tag, "clk_out low half");
      end
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   // Stimulus
   initial begin
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_data = '0;
      repeat (3) @(negedge clk);
      #3;
      for (int i = 0; i < 2; i++) begin
         chk(co[i], 1'b0, "R1", "clk_out in reset");
         chk(ce[i], 1'b0, "R1", "cfg_err in reset");
      end
      @(negedge clk);
      rst_n = 1'b1;
      tag = "R4";  repeat (12) @(negedge clk);
      tag = "R3";  wr(2, 0); repeat (20) @(negedge clk);
      tag = "R7";  wr(4, 0); repeat (2) @(negedge clk); wr(5, 0);
      repeat (40) @(negedge clk);
      tag = "R2";
      wr(3, 0);  repeat (30) @(negedge clk);
      wr(6, 0);  repeat (40) @(negedge clk);
      wr(7, 0);  repeat (45) @(negedge clk);
      wr(8, 0);  repeat (60) @(negedge clk);
      wr(10, 0); repeat (80) @(negedge clk);
      wr(11, 0); repeat (110) @(negedge clk);
      wr(1, 0);  repeat (60) @(negedge clk);
      tag = "R5";  wr(9, 0); repeat (30) @(negedge clk);
      tag = "R9";  wr(0, 0); repeat (30) @(negedge clk);
      wr(12, 0); repeat (40) @(negedge clk);
      tag = "R8";  wr(12, 1); repeat (40) @(negedge clk);
      wr(2, 0);  repeat (30) @(negedge clk);
      wr(13, 1); repeat (30) @(negedge clk);
      wr(1, 0);  repeat (30) @(negedge clk);
      tag = "R6";  wr(2, 0); repeat (20) @(negedge clk);
      tag = "R4";  wr(1, 0); repeat (20) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule